// File: doc/BRIEF.md
# Supply Supervisor with Low-Voltage Reset, Interrupt and Warning

This block watches the digital outputs of the supply comparators (power-on, low-voltage detect and two warning trip points) and from them drives the chip-wide reset, one maskable interrupt request and a set of status flags. Each comparator output passes through a synchronizer before use. A detect event leads to one of two outcomes, and the configuration picks which. It either holds the chip in reset until the supply recovers, or it sets a sticky flag that can raise an interrupt.

A small configuration register holds four controls: detect enable, reset-on-detect enable, interrupt enable and a warning trip select. While the chip is held in reset this register is forced back to its defaults. A reset-cause register records power-on and low-voltage causes. It is cleared only by the supervisor's own always-on reset. The warning flag follows the supply live and never requests an interrupt. The detect flag stays set until software acknowledges it.

Top module: `lvd_supervisor`

## Requirements
- R1: A power-on indication asserts `chip_rst_o`, and it stays asserted after the power-on indication goes away for as long as the detect comparator still reports low supply.
- R2: A power-on indication sets both `rst_cause_por_o` and `rst_cause_lvd_o` to 1.
- R3: With detect enable (cfg bit 0) and reset enable (cfg bit 1) both set, a detect event asserts `chip_rst_o`. It stays asserted until the detect comparator returns to 0.
- R4: A reset caused by low voltage alone sets `rst_cause_lvd_o` and leaves `rst_cause_por_o` unchanged. Both cause bits are cleared only by `rst_n`.
- R5: With detect enable set and reset enable clear, a detect event sets the sticky `det_flag_o` without any reset. `irq_o` is high exactly while `det_flag_o` and interrupt enable (cfg bit 2) are both set.
- R6: A one-cycle pulse on `ack_i` clears `det_flag_o` and hence `irq_o`. If a detect event is present in the same cycle, the flag stays set.
- R7: `warn_flag_o` is 1 while the selected warning comparator reports low supply and the detect comparator does not. Trip select is cfg bit 3: 1 picks `warn_hi_cmp_i` and 0 picks `warn_lo_cmp_i`. The warning never raises `irq_o`.
- R8: While `chip_rst_o` is high, the configuration reads 4'b0011 (detect and reset enabled, interrupt disabled, low trip) and configuration writes are ignored. It still reads 4'b0011 when the reset is released.
- R9: With detect enable clear, a detect event causes neither a reset nor a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low supervisor reset, released synchronously |
| por_cmp_i | input | 1 | Power-on comparator, 1 = supply below power-on level |
| lvd_cmp_i | input | 1 | Detect comparator, 1 = supply below detect level |
| warn_hi_cmp_i | input | 1 | High warning comparator, 1 = below high trip |
| warn_lo_cmp_i | input | 1 | Low warning comparator, 1 = below low trip |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 4 | Configuration write data {trip_sel, irq_en, rst_en, det_en} |
| ack_i | input | 1 | Write-one acknowledge of the detect flag |
| chip_rst_o | output | 1 | Chip reset, active high |
| irq_o | output | 1 | Interrupt request |
| rst_cause_por_o | output | 1 | Reset cause: power-on |
| rst_cause_lvd_o | output | 1 | Reset cause: low voltage |
| det_flag_o | output | 1 | Sticky detect flag |
| warn_flag_o | output | 1 | Live warning flag |
| cfg_o | output | 4 | Current configuration |

## Verification
A comparator change passes through two synchronizer flops and one result register. Reset, cause bits and both flags therefore change on the third rising edge after the input changes. The bench drives inputs just after a falling edge, waits three rising edges and samples on the next falling edge. Configuration writes and acknowledges act on the first rising edge and are sampled at the falling edge after it. The warning flag needs one further edge after a trip-select write, and the bench waits for it. `irq_o` is combinational from registered state, so it is valid in the same sample as the flag.

// File: rtl/lvd_pkg.sv
package lvd_pkg;
  typedef struct packed {
    logic trip_sel;
    logic irq_en;
    logic rst_en;
    logic det_en;
  } lvd_cfg_t;

  localparam int CFG_W   = 4;
  localparam int NUM_CMP = 4;
  localparam int CMP_POR = 0;
  localparam int CMP_LVD = 1;
  localparam int CMP_WHI = 2;
  localparam int CMP_WLO = 3;

  localparam lvd_cfg_t CFG_DEFAULT = '{trip_sel: 1'b0, irq_en: 1'b0,
                                       rst_en: 1'b1, det_en: 1'b1};
endpackage

// File: rtl/lvd_sync.sv
module lvd_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = d_i;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d;
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/lvd_reset_ctl.sv
module lvd_reset_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic por_s,
  input  logic lvd_s,
  input  logic det_en,
  input  logic rst_en,
  output logic held_o,
  output logic cause_por_o,
  output logic cause_lvd_o
);
  logic held_q, held_d;
  logic por_q, por_d;
  logic lvd_q, lvd_d;
  logic new_hold;

  always_comb begin
    if (held_q) held_d = por_s | lvd_s;
    else        held_d = por_s | (lvd_s & det_en & rst_en);
    new_hold = held_d & ~held_q;
    por_d    = por_q;
    lvd_d    = lvd_q;
    if (por_s) begin
      por_d = 1'b1;
      lvd_d = 1'b1;
    end else if (new_hold) begin
      lvd_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b1;
      por_q  <= 1'b0;
      lvd_q  <= 1'b0;
    end else begin
      held_q <= held_d;
      por_q  <= por_d;
      lvd_q  <= lvd_d;
    end
  end

  assign held_o      = held_q;
  assign cause_por_o = por_q;
  assign cause_lvd_o = lvd_q;
endmodule

// File: rtl/lvd_flag_ctl.sv
module lvd_flag_ctl
  import lvd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     held_i,
  input  logic     lvd_s,
  input  logic     whi_s,
  input  logic     wlo_s,
  input  logic     cfg_we_i,
  input  lvd_cfg_t cfg_wdata_i,
  input  logic     ack_i,
  output lvd_cfg_t cfg_o,
  output logic     det_flag_o,
  output logic     warn_flag_o,
  output logic     irq_o
);
  lvd_cfg_t cfg_q, cfg_d;
  logic det_q, det_d;
  logic warn_q, warn_d;
  logic det_set;

  always_comb begin
    if (held_i)        cfg_d = CFG_DEFAULT;
    else if (cfg_we_i) cfg_d = cfg_wdata_i;
    else               cfg_d = cfg_q;

    det_set = lvd_s & cfg_q.det_en & ~cfg_q.rst_en;
    if (held_i)       det_d = 1'b0;
    else if (det_set) det_d = 1'b1;
    else if (ack_i)   det_d = 1'b0;
    else              det_d = det_q;

    warn_d = (cfg_q.trip_sel ? whi_s : wlo_s) & ~lvd_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= CFG_DEFAULT;
      det_q  <= 1'b0;
      warn_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      det_q  <= det_d;
      warn_q <= warn_d;
    end
  end

  assign cfg_o       = cfg_q;
  assign det_flag_o  = det_q;
  assign warn_flag_o = warn_q;
  assign irq_o       = det_q & cfg_q.irq_en;
endmodule

// File: rtl/lvd_supervisor.sv
module lvd_supervisor
  import lvd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_cmp_i,
  input  logic             lvd_cmp_i,
  input  logic             warn_hi_cmp_i,
  input  logic             warn_lo_cmp_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             ack_i,
  output logic             chip_rst_o,
  output logic             irq_o,
  output logic             rst_cause_por_o,
  output logic             rst_cause_lvd_o,
  output logic             det_flag_o,
  output logic             warn_flag_o,
  output logic [CFG_W-1:0] cfg_o
);
  logic [NUM_CMP-1:0] cmp_raw, cmp_s;
  logic por_s, lvd_s;
  lvd_cfg_t cfg_q;

  assign cmp_raw[CMP_POR] = por_cmp_i;
  assign cmp_raw[CMP_LVD] = lvd_cmp_i;
  assign cmp_raw[CMP_WHI] = warn_hi_cmp_i;
  assign cmp_raw[CMP_WLO] = warn_lo_cmp_i;

  lvd_sync #(.WIDTH(NUM_CMP), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (cmp_raw),
    .q_o   (cmp_s)
  );

  assign por_s = cmp_s[CMP_POR];
  assign lvd_s = cmp_s[CMP_LVD];

  lvd_reset_ctl u_rst (
    .clk         (clk),
    .rst_n       (rst_n),
    .por_s       (por_s),
    .lvd_s       (lvd_s),
    .det_en      (cfg_q.det_en),
    .rst_en      (cfg_q.rst_en),
    .held_o      (chip_rst_o),
    .cause_por_o (rst_cause_por_o),
    .cause_lvd_o (rst_cause_lvd_o)
  );

  lvd_flag_ctl u_flag (
    .clk         (clk),
    .rst_n       (rst_n),
    .held_i      (chip_rst_o),
    .lvd_s       (lvd_s),
    .whi_s       (cmp_s[CMP_WHI]),
    .wlo_s       (cmp_s[CMP_WLO]),
    .cfg_we_i    (cfg_we_i),
    .cfg_wdata_i (lvd_cfg_t'(cfg_wdata_i)),
    .ack_i       (ack_i),
    .cfg_o       (cfg_q),
    .det_flag_o  (det_flag_o),
    .warn_flag_o (warn_flag_o),
    .irq_o       (irq_o)
  );

  assign cfg_o = cfg_q;
endmodule

// File: rtl/lvd_supervisor_chk.sv
module lvd_supervisor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       por_s,
  input logic       lvd_s,
  input logic       ack_i,
  input logic       chip_rst_o,
  input logic       irq_o,
  input logic       rst_cause_por_o,
  input logic       rst_cause_lvd_o,
  input logic       det_flag_o,
  input logic       warn_flag_o,
  input logic [3:0] cfg_o
);
  AST_POR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    por_s |=> chip_rst_o); // R1
  AST_HOLD_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_rst_o && lvd_s) |=> chip_rst_o); // R3
  AST_POR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    por_s |=> (rst_cause_por_o && rst_cause_lvd_o)); // R2
  AST_LVD_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_rst_o && lvd_s && cfg_o[0] && cfg_o[1]) |=> (chip_rst_o && rst_cause_lvd_o)); // R4
  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rst_cause_lvd_o |=> rst_cause_lvd_o); // R4
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_rst_o && lvd_s && cfg_o[0] && !cfg_o[1]) |=> det_flag_o); // R5
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !(lvd_s && cfg_o[0] && !cfg_o[1])) |=> !det_flag_o); // R6
  AST_WARN_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (warn_flag_o && !det_flag_o) |-> !irq_o); // R7
  AST_CFG_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chip_rst_o) |-> (cfg_o == 4'b0011)); // R8
  AST_NO_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_rst_o && !por_s && !cfg_o[0] && !det_flag_o) |=> (!chip_rst_o && !det_flag_o)); // R9
endmodule

bind lvd_supervisor lvd_supervisor_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .por_s           (por_s),
  .lvd_s           (lvd_s),
  .ack_i           (ack_i),
  .chip_rst_o      (chip_rst_o),
  .irq_o           (irq_o),
  .rst_cause_por_o (rst_cause_por_o),
  .rst_cause_lvd_o (rst_cause_lvd_o),
  .det_flag_o      (det_flag_o),
  .warn_flag_o     (warn_flag_o),
  .cfg_o           (cfg_o)
);

// File: tb/lvd_supervisor_bench.sv
module lvd_supervisor_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       por_cmp, lvd_cmp, whi_cmp, wlo_cmp;
  logic       cfg_we;
  logic [3:0] cfg_wdata;
  logic       ack;
  logic       chip_rst, irq, cause_por, cause_lvd, det_flag, warn_flag;
  logic [3:0] cfg;
  int         total = 0;
  int         fails = 0;

  always #5 clk = ~clk;

  lvd_supervisor u_lvd_supervisor (
    .clk             (clk),
    .rst_n           (rst_n),
    .por_cmp_i       (por_cmp),
    .lvd_cmp_i       (lvd_cmp),
    .warn_hi_cmp_i   (whi_cmp),
    .warn_lo_cmp_i   (wlo_cmp),
    .cfg_we_i        (cfg_we),
    .cfg_wdata_i     (cfg_wdata),
    .ack_i           (ack),
    .chip_rst_o      (chip_rst),
    .irq_o           (irq),
    .rst_cause_por_o (cause_por),
    .rst_cause_lvd_o (cause_lvd),
    .det_flag_o      (det_flag),
    .warn_flag_o     (warn_flag),
    .cfg_o           (cfg)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_cfg(input logic [3:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0; por_cmp = 0; lvd_cmp = 0; whi_cmp = 0; wlo_cmp = 0;
    cfg_we = 0; cfg_wdata = '0; ack = 0;
    repeat (3) @(negedge clk);
    chk("R8", "reset chip_rst", chip_rst, 1);
    chk("R4", "reset cause", {cause_por, cause_lvd}, 0);
    chk("R8", "reset cfg", cfg, 4'b0011);
    chk("R5", "reset irq", irq, 0);
    rst_n = 1'b1;
    settle();
    chk("R1", "release without supply event", chip_rst, 0);
    chk("R8", "cfg after release", cfg, 4'b0011);
  endtask

  task automatic t_lvd_reset();
    lvd_cmp = 1;
    settle();
    chk("R3", "detect reset", chip_rst, 1);
    chk("R4", "lvd cause", cause_lvd, 1);
    chk("R4", "por cause untouched", cause_por, 0);
    wr_cfg(4'b0100);
    repeat (5) @(negedge clk);
    chk("R3", "still held while low", chip_rst, 1);
    chk("R8", "write ignored while held", cfg, 4'b0011);
    lvd_cmp = 0;
    settle();
    chk("R3", "released on recovery", chip_rst, 0);
    chk("R8", "defaults after release", cfg, 4'b0011);
  endtask

  task automatic t_por();
    por_cmp = 1; lvd_cmp = 1;
    settle();
    chk("R1", "por reset", chip_rst, 1);
    chk("R2", "por cause bits", {cause_por, cause_lvd}, 2'b11);
    por_cmp = 0;
    settle();
    repeat (4) @(negedge clk);
    chk("R1", "held after por gone while low", chip_rst, 1);
    lvd_cmp = 0;
    settle();
    chk("R1", "released after detect clears", chip_rst, 0);
    chk("R2", "cause bits kept", {cause_por, cause_lvd}, 2'b11);
  endtask

  task automatic t_detect_off();
    wr_cfg(4'b0000);
    lvd_cmp = 1;
    settle();
    chk("R9", "no reset when disabled", chip_rst, 0);
    chk("R9", "no flag when disabled", det_flag, 0);
    lvd_cmp = 0;
    settle();
  endtask

  task automatic t_irq();
    wr_cfg(4'b0101);
    lvd_cmp = 1;
    settle();
    chk("R5", "no reset in irq mode", chip_rst, 0);
    chk("R5", "flag set", det_flag, 1);
    chk("R5", "irq raised", irq, 1);
    pulse_ack();
    chk("R6", "detect wins over ack", det_flag, 1);
    lvd_cmp = 0;
    settle();
    chk("R5", "flag sticky", det_flag, 1);
    pulse_ack();
    chk("R6", "ack clears flag", det_flag, 0);
    chk("R6", "ack drops irq", irq, 0);
    wr_cfg(4'b0001);
    lvd_cmp = 1;
    settle();
    chk("R5", "flag with irq masked", det_flag, 1);
    chk("R5", "irq masked", irq, 0);
    lvd_cmp = 0;
    settle();
    pulse_ack();
  endtask

  task automatic t_warn();
    wr_cfg(4'b0101);
    wlo_cmp = 1;
    settle();
    chk("R7", "low trip warn", warn_flag, 1);
    chk("R7", "warn no irq", irq, 0);
    wlo_cmp = 0; whi_cmp = 1;
    settle();
    chk("R7", "high comparator not selected", warn_flag, 0);
    wr_cfg(4'b1101);
    @(negedge clk);
    chk("R7", "high trip warn", warn_flag, 1);
    chk("R7", "warn no irq high", irq, 0);
    lvd_cmp = 1;
    settle();
    chk("R7", "warn off below detect", warn_flag, 0);
    chk("R5", "detect flag below detect", det_flag, 1);
    lvd_cmp = 0; whi_cmp = 0;
    settle();
    pulse_ack();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset_state();
    t_lvd_reset();
    t_por();
    t_detect_off();
    t_irq();
    t_warn();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule